// File: doc/BRIEF.md
# Block String Compare Unit

This unit compares two strings held in memory, one element at a time. A start pulse loads a source index, a destination index, a repeat count, the current arithmetic flags and a configuration. For each element the unit reads the source operand and then the destination operand through a request/acknowledge memory port. It subtracts the destination operand from the source operand and keeps only the resulting flags. It then moves both indexes by the element size, in the direction given by a direction bit.

Elements are 1, 2 or 4 bytes wide. Indexes and the count are 32 bits wide. In narrow-address mode only their low halves take part, and the upper halves are kept as they were. Three run modes are available: a single compare; repeat while the elements are equal; and repeat while they differ. Each read also reports a segment select. Destination reads always use the extra segment. Source reads use the data segment unless an override is supplied. When the operation ends, a one-cycle done pulse presents the final indexes, count and flags.

Top module: `blkcmp_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all 0. While idle, no read is requested and `done` stays low.
- R2: Each compare computes source element minus destination element and writes only `flags`, with bit layout [5]=OF, [4]=SF, [3]=ZF, [2]=AF, [1]=PF, [0]=CF. The flags are set as follows:
  - CF is the unsigned borrow.
  - ZF is set when the element-width result is zero.
  - SF is the result's top bit.
  - AF is the borrow out of bit 3.
  - PF is set when the low result byte has an even number of ones.
  - OF is set when the operand signs differ and the result sign differs from the source sign.
- R3: `elem_size` encodes 0 = byte, 1 = word, 2 = doubleword. After each compare, both indexes move by 1, 2 or 4 to match.
- R4: With `dir_down` = 0 the indexes increase. With `dir_down` = 1 they decrease.
- R5: With `addr_wide` = 0, index and count updates wrap within the low 16 bits and leave bits 31:16 unchanged. In this mode, bits 31:16 of `mem_addr` are 0.
- R6: Segment select codes are 0 = extra segment and 3 = data segment. Destination reads always carry code 0. Source reads carry code 3, or `seg_ovr` when `seg_ovr_en` is 1.
- R7: Each compare makes exactly two reads: the source first, then the destination. Each request holds its address and segment until `mem_ack`.
- R8: In a repeat mode, a count of zero checked before an element ends the run with no read and the flags unchanged. Otherwise the count decreases by one after each compare.
- R9: `rep_mode` = 1 (repeat while equal) stops after a compare that clears ZF.
- R10: `rep_mode` = 2 (repeat while not equal) stops after a compare that sets ZF.
- R11: `rep_mode` = 0 or 3 performs exactly one compare regardless of the count, and leaves the count unchanged.
- R12: `done` is high for exactly one cycle at the end of a run, and the unit is idle on the next cycle. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| elem_size | input | 2 | Element size: 0 byte, 1 word, 2 doubleword |
| addr_wide | input | 1 | 1 = 32-bit indexes and count, 0 = low 16 bits |
| dir_down | input | 1 | 1 = indexes decrease |
| rep_mode | input | 2 | 0/3 single, 1 repeat while equal, 2 repeat while not equal |
| seg_ovr_en | input | 1 | Use `seg_ovr` for source reads |
| seg_ovr | input | 3 | Override segment select for source reads |
| src_init | input | 32 | Starting source index |
| dst_init | input | 32 | Starting destination index |
| cnt_init | input | 32 | Starting repeat count |
| flags_init | input | 6 | Flags in force before the operation |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read offset |
| mem_seg | output | 3 | Segment select for the read |
| mem_size | output | 2 | Element size of the read |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data, element in the low bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| src_idx | output | 32 | Current source index |
| dst_idx | output | 32 | Current destination index |
| count | output | 32 | Current repeat count |
| flags | output | 6 | Current flags {OF,SF,ZF,AF,PF,CF} |

## Verification
The interesting coincidence is the count running out on the same element whose compare also meets the mismatch stop condition. Both stop causes then act in one commit cycle. The bench provokes this with a repeat-while-equal run whose strings differ only in their last element. It expects exactly one done pulse, a count of zero, both indexes advanced over every element, and flags from the final subtraction with ZF clear. A second coincidence is a start pulse that arrives mid-run. That pulse must leave the run's indexes and read count untouched.

// File: rtl/blkcmp_pkg.sv
package blkcmp_pkg;

    localparam int IDX_W  = 32;
    localparam int DATA_W = 32;
    localparam int SEG_W  = 3;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } esize_t;

    typedef enum logic [1:0] {
        RP_ONCE     = 2'd0,
        RP_WHILE_EQ = 2'd1,
        RP_WHILE_NE = 2'd2,
        RP_ONCE_ALT = 2'd3
    } rmode_t;

    localparam logic [SEG_W-1:0] SEG_XTRA = 3'd0;
    localparam logic [SEG_W-1:0] SEG_DATA = 3'd3;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } aflags_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEST,
        ST_RSRC,
        ST_RDST,
        ST_EXEC,
        ST_FIN
    } ph_t;

    function automatic logic [2:0] step_of(input logic [1:0] sz);
        case (sz)
            2'd0:    step_of = 3'd1;
            2'd1:    step_of = 3'd2;
            default: step_of = 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] elem_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    elem_mask = DATA_W'(8'hFF);
            2'd1:    elem_mask = DATA_W'(16'hFFFF);
            default: elem_mask = '1;
        endcase
    endfunction

endpackage

// File: rtl/blkcmp_flags.sv
module blkcmp_flags
    import blkcmp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    sz,
    output aflags_t       f
);
    logic [DW-1:0] msk, am, bm, r;
    logic [DW:0]   d;
    logic [4:0]    nib;
    logic          sa, sb, sr;

    always_comb begin
        msk = DW'(elem_mask(sz));
        am  = a & msk;
        bm  = b & msk;
        d   = {1'b0, am} - {1'b0, bm};
        r   = d[DW-1:0] & msk;
        nib = {1'b0, am[3:0]} - {1'b0, bm[3:0]};
        case (sz)
            2'd0:    begin sa = am[7];    sb = bm[7];    sr = r[7];    end
            2'd1:    begin sa = am[15];   sb = bm[15];   sr = r[15];   end
            default: begin sa = am[DW-1]; sb = bm[DW-1]; sr = r[DW-1]; end
        endcase
        f.cf = d[DW];
        f.zf = (r == '0);
        f.sf = sr;
        f.af = nib[4];
        f.pf = ~^r[7:0];
        f.of = (sa != sb) && (sr != sa);
    end
endmodule

// File: rtl/blkcmp_adv.sv
module blkcmp_adv #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic [2:0]   delta,
    input  logic         down,
    input  logic         wide,
    output logic [W-1:0] nxt
);
    localparam int HW = W / 2;

    logic [W-1:0] d_ext, full;

    always_comb begin
        d_ext = W'(delta);
        full  = down ? (val - d_ext) : (val + d_ext);
        nxt   = wide ? full : {val[W-1:HW], full[HW-1:0]};
    end
endmodule

// File: rtl/blkcmp_seq.sv
module blkcmp_seq
    import blkcmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mem_ack,
    input  logic repeat_on,
    input  logic cnt_zero,
    input  logic stop_hit,
    output logic load,
    output logic cap_src,
    output logic cap_dst,
    output logic commit,
    output logic rd_req,
    output logic rd_dst,
    output logic busy,
    output logic done
);
    ph_t st, st_n;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_n;
    end

    always_comb begin
        st_n    = st;
        load    = 1'b0;
        cap_src = 1'b0;
        cap_dst = 1'b0;
        commit  = 1'b0;
        rd_req  = 1'b0;
        rd_dst  = 1'b0;
        done    = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    st_n = ST_TEST;
                end
            end
            ST_TEST: st_n = (repeat_on && cnt_zero) ? ST_FIN : ST_RSRC;
            ST_RSRC: begin
                rd_req = 1'b1;
                if (mem_ack) begin
                    cap_src = 1'b1;
                    st_n    = ST_RDST;
                end
            end
            ST_RDST: begin
                rd_req = 1'b1;
                rd_dst = 1'b1;
                if (mem_ack) begin
                    cap_dst = 1'b1;
                    st_n    = ST_EXEC;
                end
            end
            ST_EXEC: begin
                commit = 1'b1;
                st_n   = (!repeat_on || stop_hit) ? ST_FIN : ST_TEST;
            end
            ST_FIN: begin
                done = 1'b1;
                st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/blkcmp_engine.sv
module blkcmp_engine
    import blkcmp_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int DW = DATA_W,
    parameter int SW = SEG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    elem_size,
    input  logic          addr_wide,
    input  logic          dir_down,
    input  logic [1:0]    rep_mode,
    input  logic          seg_ovr_en,
    input  logic [SW-1:0] seg_ovr,
    input  logic [IW-1:0] src_init,
    input  logic [IW-1:0] dst_init,
    input  logic [IW-1:0] cnt_init,
    input  logic [5:0]    flags_init,
    output logic          mem_req,
    output logic [IW-1:0] mem_addr,
    output logic [SW-1:0] mem_seg,
    output logic [1:0]    mem_size,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] src_idx,
    output logic [IW-1:0] dst_idx,
    output logic [IW-1:0] count,
    output logic [5:0]    flags
);
    localparam int HW = IW / 2;

    logic [1:0]    sz_q;
    logic          wide_q, down_q;
    rmode_t        mode_q;
    logic [SW-1:0] sseg_q;
    logic [IW-1:0] src_q, dst_q, cnt_q;
    logic [DW-1:0] opa_q, opb_q;
    aflags_t       flg_q, flg_new;

    logic load, cap_src, cap_dst, commit, rd_dst;
    logic repeat_on, cnt_zero, stop_hit;
    logic [IW-1:0] src_nx, dst_nx, cnt_nx;
    logic [2:0]    step;

    assign step      = step_of(sz_q);
    assign repeat_on = (mode_q == RP_WHILE_EQ) || (mode_q == RP_WHILE_NE);
    assign cnt_zero  = wide_q ? (cnt_q == '0) : (cnt_q[HW-1:0] == '0);
    assign stop_hit  = ((mode_q == RP_WHILE_EQ) && !flg_new.zf) ||
                       ((mode_q == RP_WHILE_NE) &&  flg_new.zf);

    blkcmp_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .mem_ack(mem_ack),
        .repeat_on(repeat_on), .cnt_zero(cnt_zero), .stop_hit(stop_hit),
        .load(load), .cap_src(cap_src), .cap_dst(cap_dst), .commit(commit),
        .rd_req(mem_req), .rd_dst(rd_dst), .busy(busy), .done(done)
    );

    blkcmp_flags #(.DW(DW)) u_flags (
        .a(opa_q), .b(opb_q), .sz(sz_q), .f(flg_new)
    );

    blkcmp_adv #(.W(IW)) u_src_adv (
        .val(src_q), .delta(step), .down(down_q), .wide(wide_q), .nxt(src_nx)
    );
    blkcmp_adv #(.W(IW)) u_dst_adv (
        .val(dst_q), .delta(step), .down(down_q), .wide(wide_q), .nxt(dst_nx)
    );
    blkcmp_adv #(.W(IW)) u_cnt_adv (
        .val(cnt_q), .delta(3'd1), .down(1'b1), .wide(wide_q), .nxt(cnt_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sz_q   <= 2'd0;
            wide_q <= 1'b1;
            down_q <= 1'b0;
            mode_q <= RP_ONCE;
            sseg_q <= SEG_DATA;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            flg_q  <= '0;
        end else begin
            if (load) begin
                sz_q   <= elem_size;
                wide_q <= addr_wide;
                down_q <= dir_down;
                mode_q <= rmode_t'(rep_mode);
                sseg_q <= seg_ovr_en ? seg_ovr : SEG_DATA;
                src_q  <= src_init;
                dst_q  <= dst_init;
                cnt_q  <= cnt_init;
                flg_q  <= aflags_t'(flags_init);
            end
            if (cap_src) opa_q <= mem_rdata;
            if (cap_dst) opb_q <= mem_rdata;
            if (commit) begin
                src_q <= src_nx;
                dst_q <= dst_nx;
                flg_q <= flg_new;
                if (repeat_on) cnt_q <= cnt_nx;
            end
        end
    end

    logic [IW-1:0] raw_addr;
    assign raw_addr = rd_dst ? dst_q : src_q;
    assign mem_addr = wide_q ? raw_addr : {{(IW-HW){1'b0}}, raw_addr[HW-1:0]};
    assign mem_seg  = rd_dst ? SEG_XTRA : sseg_q;
    assign mem_size = sz_q;

    assign src_idx = src_q;
    assign dst_idx = dst_q;
    assign count   = cnt_q;
    assign flags   = flg_q;
endmodule

// File: rtl/blkcmp_chk.sv
module blkcmp_chk
    import blkcmp_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int SW = SEG_W
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [IW-1:0] mem_addr,
    input logic [SW-1:0] mem_seg,
    input logic          busy,
    input logic          done,
    input logic          wide_q,
    input logic          rd_dst
);
    localparam int HW = IW / 2;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !done));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R5
    narrow_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !wide_q) |-> (mem_addr[IW-1:HW] == '0));

    // R7
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_seg)));

    // R7
    src_first_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !rd_dst) |=> (mem_req && rd_dst));

    // R6
    dst_seg_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && rd_dst) |-> (mem_seg == SEG_XTRA));
endmodule

bind blkcmp_engine blkcmp_chk #(.IW(IW), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_seg(mem_seg), .busy(busy), .done(done),
    .wide_q(wide_q), .rd_dst(rd_dst)
);

// File: tb/tb_blkcmp_engine.sv
`timescale 1ns/1ps
module tb_blkcmp_engine;
    logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [1:0]  elem_size = 2'd0;
    logic        addr_wide = 1'b1, dir_down = 1'b0;
    logic [1:0]  rep_mode = 2'd0;
    logic        seg_ovr_en = 1'b0;
    logic [2:0]  seg_ovr = 3'd0;
    logic [31:0] src_init = '0, dst_init = '0, cnt_init = '0;
    logic [5:0]  flags_init = '0;
    logic        mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic [2:0]  mem_seg;
    logic [1:0]  mem_size;
    logic        busy, done;
    logic [31:0] src_idx, dst_idx, count;
    logic [5:0]  flags;

    int checks = 0, errors = 0, nreads = 0, bad_hi = 0;
    logic [2:0] last_src_seg = 3'd0;
    logic [7:0] smem [256];
    logic [7:0] dmem [256];

    always #2 clk = ~clk;

    blkcmp_engine dut (
        .clk(clk), .rst(rst), .start(start), .elem_size(elem_size),
        .addr_wide(addr_wide), .dir_down(dir_down), .rep_mode(rep_mode),
        .seg_ovr_en(seg_ovr_en), .seg_ovr(seg_ovr), .src_init(src_init),
        .dst_init(dst_init), .cnt_init(cnt_init), .flags_init(flags_init),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_seg(mem_seg),
        .mem_size(mem_size), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .src_idx(src_idx), .dst_idx(dst_idx),
        .count(count), .flags(flags)
    );

    function automatic logic [31:0] rd4(input logic is_dst, input logic [7:0] a);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            v[8*k +: 8] = is_dst ? dmem[8'(a + 8'(k))] : smem[8'(a + 8'(k))];
        end
        return v;
    endfunction

    // memory model: answers one cycle after each new request, at the falling edge
    always @(negedge clk) begin
        if (mem_req === 1'b1 && !mem_ack) begin
            mem_ack   = 1'b1;
            mem_rdata = rd4(mem_seg == 3'd0, mem_addr[7:0]);
            nreads++;
            if (mem_seg != 3'd0) last_src_seg = mem_seg;
            if (!addr_wide && mem_addr[31:16] != 16'h0) bad_hi++;
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] sz, input logic wide, input logic down,
                          input logic [1:0] mode, input logic oen, input logic [2:0] oseg,
                          input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c, input logic [5:0] f);
        @(negedge clk);
        nreads = 0; bad_hi = 0;
        elem_size = sz; addr_wide = wide; dir_down = down; rep_mode = mode;
        seg_ovr_en = oen; seg_ovr = oseg;
        src_init = s; dst_init = d; cnt_init = c; flags_init = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (done !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (done !== 1'b1) begin
            checks++; errors++;
            $display("FAIL %s: done actual 0 expected 1", req);
        end
    endtask

    task automatic check_pulse_end(input string req);
        @(negedge clk);
        check(req, "done after pulse", 32'(done), 32'd0);
        check(req, "busy after pulse", 32'(busy), 32'd0);
    endtask

    task automatic test_reset();
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "mem_req", 32'(mem_req), 32'd0);
    endtask

    task automatic test_single_byte();
        smem[8'h10] = 8'h05; dmem[8'h20] = 8'h07;
        launch(2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 3'd0, 32'h10, 32'h20, 32'h33, 6'h00);
        wait_done("R11");
        check("R2", "flags 05-07", 32'(flags), 32'(6'b010101));
        check("R3", "src step byte", src_idx, 32'h11);
        check("R3", "dst step byte", dst_idx, 32'h21);
        check("R11", "count untouched", count, 32'h33);
        check("R7", "reads per compare", nreads, 2);
        check("R6", "default source segment", 32'(last_src_seg), 32'd3);
        check_pulse_end("R12");
    endtask

    task automatic test_word_down_override();
        smem[8'h40] = 8'h00; smem[8'h41] = 8'h80;
        dmem[8'h50] = 8'h01; dmem[8'h51] = 8'h00;
        launch(2'd1, 1'b1, 1'b1, 2'd3, 1'b1, 3'd4, 32'h40, 32'h50, 32'h9, 6'h00);
        wait_done("R11");
        check("R2", "flags 8000-0001", 32'(flags), 32'(6'b100110));
        check("R4", "src step down word", src_idx, 32'h3E);
        check("R4", "dst step down word", dst_idx, 32'h4E);
        check("R6", "override segment", 32'(last_src_seg), 32'd4);
        check("R11", "single compare reads", nreads, 2);
        check("R11", "count untouched alt", count, 32'h9);
    endtask

    task automatic test_repe_dword();
        for (int k = 0; k < 4; k++) begin
            smem[8'(8'h60 + k)] = 8'(32'h11223344 >> (8*k));
            dmem[8'(8'hA0 + k)] = 8'(32'h11223344 >> (8*k));
            smem[8'(8'h64 + k)] = 8'(32'hCAFEBABE >> (8*k));
            dmem[8'(8'hA4 + k)] = 8'(32'hCAFEBABE >> (8*k));
            smem[8'(8'h68 + k)] = 8'(32'h00000010 >> (8*k));
            dmem[8'(8'hA8 + k)] = 8'(32'h00000020 >> (8*k));
        end
        launch(2'd2, 1'b1, 1'b0, 2'd1, 1'b0, 3'd0, 32'h60, 32'hA0, 32'd5, 6'h00);
        wait_done("R9");
        check("R9", "reads until mismatch", nreads, 6);
        check("R8", "count after 3 compares", count, 32'd2);
        check("R3", "src step dword", src_idx, 32'h6C);
        check("R3", "dst step dword", dst_idx, 32'hAC);
        check("R2", "flags 10-20 dword", 32'(flags), 32'(6'b010011));
    endtask

    task automatic test_repne_byte();
        smem[8'hC0] = 8'd1; smem[8'hC1] = 8'd2; smem[8'hC2] = 8'd3; smem[8'hC3] = 8'd4;
        dmem[8'hE0] = 8'd9; dmem[8'hE1] = 8'd2; dmem[8'hE2] = 8'd7; dmem[8'hE3] = 8'd4;
        launch(2'd0, 1'b1, 1'b0, 2'd2, 1'b0, 3'd0, 32'hC0, 32'hE0, 32'd4, 6'h00);
        wait_done("R10");
        check("R10", "reads until match", nreads, 4);
        check("R10", "count after match", count, 32'd2);
        check("R10", "src after match", src_idx, 32'hC2);
        check("R10", "flags equal", 32'(flags), 32'(6'b001010));
    endtask

    task automatic test_zero_count();
        launch(2'd1, 1'b1, 1'b0, 2'd1, 1'b0, 3'd0, 32'h1000, 32'h2000, 32'd0, 6'b101101);
        wait_done("R8");
        check("R8", "no reads on zero count", nreads, 0);
        check("R8", "flags unchanged", 32'(flags), 32'(6'b101101));
        check("R8", "src unchanged", src_idx, 32'h1000);
        check_pulse_end("R12");
        launch(2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 3'd0, 32'h5, 32'h6, 32'h00050000, 6'b000001);
        wait_done("R8");
        check("R8", "narrow zero count reads", nreads, 0);
        check("R8", "narrow count kept", count, 32'h00050000);
        check("R8", "narrow flags kept", 32'(flags), 32'(6'b000001));
    endtask

    task automatic test_wrap16_up();
        smem[8'hFF] = 8'h5A; dmem[8'hFF] = 8'h5A;
        launch(2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 3'd0, 32'hABCDFFFF, 32'h1234FFFF, 32'h77770001, 6'h00);
        wait_done("R5");
        check("R5", "src wrap up", src_idx, 32'hABCD0000);
        check("R5", "dst wrap up", dst_idx, 32'h12340000);
        check("R5", "count low half", count, 32'h77770000);
        check("R5", "upper address bits", bad_hi, 0);
        check("R8", "one compare", nreads, 2);
    endtask

    task automatic test_wrap16_down();
        smem[8'h00] = 8'h03; smem[8'h01] = 8'h00;
        dmem[8'h01] = 8'h03; dmem[8'h02] = 8'h00;
        launch(2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 3'd0, 32'h55550000, 32'h66660001, 32'h0, 6'h00);
        wait_done("R5");
        check("R5", "src wrap down", src_idx, 32'h5555FFFE);
        check("R4", "dst wrap down", dst_idx, 32'h6666FFFF);
        check("R2", "flags equal words", 32'(flags), 32'(6'b001010));
        check("R5", "upper address bits down", bad_hi, 0);
    endtask

    task automatic test_last_elem_mismatch();
        smem[8'h30] = 8'h34; smem[8'h31] = 8'h12; dmem[8'h90] = 8'h34; dmem[8'h91] = 8'h12;
        smem[8'h32] = 8'hAD; smem[8'h33] = 8'h0B; dmem[8'h92] = 8'hAD; dmem[8'h93] = 8'h0B;
        smem[8'h34] = 8'h01; smem[8'h35] = 8'h00; dmem[8'h94] = 8'h02; dmem[8'h95] = 8'h00;
        launch(2'd1, 1'b1, 1'b0, 2'd1, 1'b0, 3'd0, 32'h30, 32'h90, 32'd3, 6'h00);
        wait_done("R9");
        check("R8", "count exhausted", count, 32'd0);
        check("R9", "flags last mismatch", 32'(flags), 32'(6'b010111));
        check("R9", "src over all elements", src_idx, 32'h36);
        check("R7", "reads all elements", nreads, 6);
        check_pulse_end("R12");
    endtask

    task automatic test_busy_start();
        smem[8'hD0] = 8'd1; smem[8'hD1] = 8'd1; smem[8'hD2] = 8'd1;
        dmem[8'hF0] = 8'd2; dmem[8'hF1] = 8'd2; dmem[8'hF2] = 8'd2;
        launch(2'd0, 1'b1, 1'b0, 2'd2, 1'b0, 3'd0, 32'hD0, 32'hF0, 32'd3, 6'h00);
        repeat (3) @(negedge clk);
        src_init = 32'h0; dst_init = 32'h0; cnt_init = 32'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R12");
        check("R12", "src ignores late start", src_idx, 32'hD3);
        check("R12", "reads ignore late start", nreads, 6);
        check("R10", "count runs out", count, 32'd0);
        check("R10", "flags 01-02", 32'(flags), 32'(6'b010111));
        check_pulse_end("R12");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            smem[i] = 8'h00;
            dmem[i] = 8'h00;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_single_byte();
        test_word_down_override();
        test_repe_dword();
        test_repne_byte();
        test_zero_count();
        test_wrap16_up();
        test_wrap16_down();
        test_last_elem_mismatch();
        test_busy_start();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule